// File: doc/BRIEF.md
# Modulated PWM Edge Timing Generator

This block drives one synchronous-rectifier gate signal inside a repeating switching period. Software supplies a rising-edge time and a falling-edge time, each a 12-bit count of 5 ns units split into an upper byte and a lower nibble. Each clock of the block is one 40 ns coarse step, and each edge time is resolved into a coarse step index plus a 3-bit fine offset. The coarse drive pulse and the two fine offsets for the current period are presented to a downstream delay stage.

A signed modulation value from a control loop can shift either edge. Each edge has its own enable and direction bit. Shifted edges saturate inside the period. Edges may cross, so the pulse wraps across the period boundary. A control bit can restrict that crossing to the soft-start ramp. The soft start grows the pulse width by a fixed increment per period until the programmed width is reached. It runs either on every enable or only on the first enable after reset.

A state machine with three states, ST_OFF, ST_RAMP and ST_RUN, sequences the block. Its transitions are:
- ST_OFF to ST_RAMP, on enable when a soft start is due.
- ST_OFF to ST_RUN, on enable otherwise.
- ST_RAMP to ST_RUN, at a period boundary where the ramp width reaches the target.
- ST_RAMP to ST_OFF and ST_RUN to ST_OFF, when enable drops.

Top module: `pwm_edge_gen`

## Requirements
- R1: An edge time is {upper byte, lower nibble} in 5 ns units. Coarse step k covers units 8k..8k+7, and the period has ceil(period/8) steps (period ≥ 16). With effective rise r and fall f (f ≥ r), `drive` is high in steps r/8 through f/8−1. `period_start` is high in step 0. `rise_fine` = r mod 8 and `fall_fine` = f mod 8 while a pulse is present, otherwise 0.
- R2: If the effective rise and fall land in the same coarse step, `drive` stays low for the whole period.
- R3: Every effective edge time is saturated to the range 0..period−1, so the pulse never exceeds period minus one unit.
- R4: An edge whose modulation enable is 0 sits at its programmed time, whatever `mod_val` holds.
- R5: With its direction bit 0 an enabled edge moves by +`mod_val`. With the bit 1 it moves by −`mod_val`.
- R6: With `cross_ss_only` = 0 and fall < rise, the pulse wraps. It runs from the rise step to the period end and from step 0 up to the fall step.
- R7: With `cross_ss_only` = 1, crossed edges produce no pulse, except in periods loaded while a ramp is starting or under way.
- R8: During a ramp, the width in period k after enable is min(target, SS_INC·(k+1)), and `ss_active` is high. The ramp ends at the first boundary k ≥ 1 where SS_INC·(k+1) ≥ target.
- R9: `ss_done` goes high when a ramp reaches its target and is cleared when a new ramp starts. It is never high together with `ss_active`.
- R10: With `ss_repeat` = 0, a ramp runs only on the first enable after reset. With `ss_repeat` = 1, a ramp runs on every enable with `ss_en` = 1.
- R11: `cfg_err` is high one cycle after `ss_en` = 1 while the programmed rise time is in 16..23 units (80..115 ns). Otherwise it is low.
- R12: After reset, and one cycle after `en` is low, `drive`, `period_start` and `ss_active` are low.
- R13: Period, edge, modulation and control inputs are captured at period start. Changes made mid-period act from the next period on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coarse step clock (one 40 ns step per cycle) |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Output enable |
| period | input | 12 | Switching period in 5 ns units |
| rise_hi | input | 8 | Upper bits of rising-edge time |
| rise_lo | input | 4 | Lower bits of rising-edge time |
| fall_hi | input | 8 | Upper bits of falling-edge time |
| fall_lo | input | 4 | Lower bits of falling-edge time |
| rise_mod_en | input | 1 | Modulation shifts the rising edge |
| rise_mod_neg | input | 1 | Rising edge moves earlier with positive modulation |
| fall_mod_en | input | 1 | Modulation shifts the falling edge |
| fall_mod_neg | input | 1 | Falling edge moves earlier with positive modulation |
| cross_ss_only | input | 1 | Allow edge crossing only during the ramp |
| ss_en | input | 1 | Soft start enable |
| ss_repeat | input | 1 | Ramp on every enable |
| mod_val | input | 10 | Signed modulation value in 5 ns units |
| drive | output | 1 | Coarse gate drive |
| rise_fine | output | 3 | Fine offset of the rising edge in the current period |
| fall_fine | output | 3 | Fine offset of the falling edge in the current period |
| period_start | output | 1 | High in the first step of each period |
| ss_active | output | 1 | Soft-start ramp in progress |
| ss_done | output | 1 | Last ramp reached its target |
| cfg_err | output | 1 | Rise setting inside the range banned under soft start |

## Verification
The hardest situation to reach is a soft-start ramp whose edges are crossed while `cross_ss_only` is set. In that case the target width itself changes at the boundary where the ramp hands over to normal running. The last ramp period wraps, and the following period collapses to no pulse. Reaching it needs `ss_en`, crossed edges and the crossing restriction together, plus a first enable or `ss_repeat`. The random stimulus therefore draws rise and fall independently over a range wider than the period. It turns on soft start in a third of the configurations and keeps each soft-start run long enough to cover the whole ramp. The bench follows the ramp period by period from its own model.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RAMP = 2'd1,
        ST_RUN  = 2'd2
    } run_state_t;

endpackage

// File: rtl/pwm_edge_adjust.sv
// Applies a signed shift to one programmed edge time and saturates the
// result into 0..period_max.
module pwm_edge_adjust #(
    parameter int TW = 12,
    parameter int MW = 10
) (
    input  logic [TW-1:0]        base,
    input  logic [TW-1:0]        period_max,
    input  logic signed [MW-1:0] mod_val,
    input  logic                 mod_en,
    input  logic                 mod_neg,
    output logic [TW-1:0]        edge_out
);
    localparam int EW = ((TW > MW) ? TW : MW) + 2;

    logic signed [EW-1:0] base_s;
    logic signed [EW-1:0] mod_s;
    logic signed [EW-1:0] lim_s;
    logic signed [EW-1:0] shift_s;
    logic signed [EW-1:0] sum_s;

    always_comb begin
        base_s  = $signed({{(EW-TW){1'b0}}, base});
        lim_s   = $signed({{(EW-TW){1'b0}}, period_max});
        mod_s   = $signed({{(EW-MW){mod_val[MW-1]}}, mod_val});
        shift_s = '0;
        if (mod_en) begin
            shift_s = mod_neg ? -mod_s : mod_s;
        end
        sum_s = base_s + shift_s;
        if (sum_s[EW-1]) begin
            edge_out = '0;
        end else if (sum_s > lim_s) begin
            edge_out = period_max;
        end else begin
            edge_out = sum_s[TW-1:0];
        end
    end
endmodule

// File: rtl/pwm_pulse_shaper.sv
// Turns a pair of effective edges into coarse step indices, fine offsets
// and a pulse-present flag, applying the crossing rule, the width cap and
// an optional ramp limit.
module pwm_pulse_shaper #(
    parameter int TW = 12,
    parameter int FW = 3,
    localparam int SW = TW - FW
) (
    input  logic [TW-1:0] r_edge,
    input  logic [TW-1:0] f_edge,
    input  logic [TW-1:0] period,
    input  logic [TW-1:0] limit,
    input  logic          lim_en,
    input  logic          cross_ok,
    output logic [SW-1:0] r_step,
    output logic [SW-1:0] f_step,
    output logic [FW-1:0] r_fine,
    output logic [FW-1:0] f_fine,
    output logic          pulse_on,
    output logic          wrap,
    output logic [TW-1:0] tgt_w
);
    logic [TW:0] r_x, f_x, p_x, lim_x;
    logic [TW:0] raw_w, cap_w, w1, w2, fe;
    logic        crossed;

    always_comb begin
        r_x     = {1'b0, r_edge};
        f_x     = {1'b0, f_edge};
        p_x     = {1'b0, period};
        lim_x   = {1'b0, limit};
        crossed = (f_x < r_x);
        if (!crossed) begin
            raw_w = f_x - r_x;
        end else if (cross_ok) begin
            raw_w = p_x - r_x + f_x;
        end else begin
            raw_w = '0;
        end
        cap_w = p_x - 1'b1;
        w1    = (raw_w > cap_w) ? cap_w : raw_w;
        w2    = (lim_en && (lim_x < w1)) ? lim_x : w1;
        fe    = r_x + w2;
        if (fe >= p_x) begin
            fe = fe - p_x;
        end
        tgt_w    = w1[TW-1:0];
        r_step   = r_x[TW-1:FW];
        f_step   = fe[TW-1:FW];
        r_fine   = r_x[FW-1:0];
        f_fine   = fe[FW-1:0];
        pulse_on = (r_step != f_step);
        wrap     = (f_step < r_step);
    end
endmodule

// File: rtl/pwm_step_timer.sv
// Coarse step counter within one switching period.
module pwm_step_timer #(
    parameter int SW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          load,
    input  logic [SW-1:0] last_step,
    output logic [SW-1:0] step,
    output logic          at_last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step <= '0;
        end else if (load) begin
            step <= '0;
        end else if (run) begin
            step <= step + 1'b1;
        end else begin
            step <= '0;
        end
    end

    assign at_last = (step == last_step);
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
    import pwm_edge_pkg::*;
#(
    parameter int HI_W   = 8,
    parameter int LO_W   = 4,
    parameter int FW     = 3,
    parameter int MW     = 10,
    parameter int SS_INC = 8,
    parameter int BAN_LO = 16,
    parameter int BAN_HI = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [HI_W+LO_W-1:0]   period,
    input  logic [HI_W-1:0]        rise_hi,
    input  logic [LO_W-1:0]        rise_lo,
    input  logic [HI_W-1:0]        fall_hi,
    input  logic [LO_W-1:0]        fall_lo,
    input  logic                   rise_mod_en,
    input  logic                   rise_mod_neg,
    input  logic                   fall_mod_en,
    input  logic                   fall_mod_neg,
    input  logic                   cross_ss_only,
    input  logic                   ss_en,
    input  logic                   ss_repeat,
    input  logic signed [MW-1:0]   mod_val,
    output logic                   drive,
    output logic [FW-1:0]          rise_fine,
    output logic [FW-1:0]          fall_fine,
    output logic                   period_start,
    output logic                   ss_active,
    output logic                   ss_done,
    output logic                   cfg_err
);
    localparam int TW     = HI_W + LO_W;
    localparam int SW     = TW - FW;
    localparam int NEDGE  = 2;
    localparam int SUBSTP = 1 << FW;

    run_state_t state, state_nx;

    // edge adjustment, one instance per edge (0 = rise, 1 = fall)
    logic [TW-1:0] edge_base [NEDGE];
    logic          edge_men  [NEDGE];
    logic          edge_mneg [NEDGE];
    logic [TW-1:0] edge_eff  [NEDGE];
    logic [TW-1:0] pmax;

    assign edge_base[0] = {rise_hi, rise_lo};
    assign edge_base[1] = {fall_hi, fall_lo};
    assign edge_men[0]  = rise_mod_en;
    assign edge_men[1]  = fall_mod_en;
    assign edge_mneg[0] = rise_mod_neg;
    assign edge_mneg[1] = fall_mod_neg;
    assign pmax         = period - 1'b1;

    for (genvar g = 0; g < NEDGE; g++) begin : g_edge
        pwm_edge_adjust #(.TW(TW), .MW(MW)) u_adj (
            .base       (edge_base[g]),
            .period_max (pmax),
            .mod_val    (mod_val),
            .mod_en     (edge_men[g]),
            .mod_neg    (edge_mneg[g]),
            .edge_out   (edge_eff[g])
        );
    end

    // soft-start control terms
    logic          start_ramp;
    logic          ramp_now;
    logic          cross_ok;
    logic          load;
    logic          at_last;
    logic          done_set;
    logic [TW-1:0] ss_w;
    logic [TW-1:0] ss_w_next;
    logic [TW:0]   ss_sum;
    logic          ss_seen;
    logic          ss_done_q;
    logic          cfg_err_q;

    assign start_ramp = (state == ST_OFF) && en && ss_en && (ss_repeat || !ss_seen);
    assign ramp_now   = start_ramp || ((state == ST_RAMP) && en);
    assign cross_ok   = !cross_ss_only || ramp_now;
    assign load       = en && ((state == ST_OFF) || at_last);
    assign ss_sum     = {1'b0, ss_w} + (TW+1)'(SS_INC);

    always_comb begin
        if (state == ST_OFF) begin
            ss_w_next = TW'(SS_INC);
        end else if (ss_sum[TW]) begin
            ss_w_next = '1;
        end else begin
            ss_w_next = ss_sum[TW-1:0];
        end
    end

    // shaper for the period about to be loaded
    logic [SW-1:0] sh_rstep, sh_fstep;
    logic [FW-1:0] sh_rfine, sh_ffine;
    logic          sh_on, sh_wrap;
    logic [TW-1:0] sh_tgt;

    pwm_pulse_shaper #(.TW(TW), .FW(FW)) u_shape (
        .r_edge   (edge_eff[0]),
        .f_edge   (edge_eff[1]),
        .period   (period),
        .limit    (ss_w_next),
        .lim_en   (ramp_now),
        .cross_ok (cross_ok),
        .r_step   (sh_rstep),
        .f_step   (sh_fstep),
        .r_fine   (sh_rfine),
        .f_fine   (sh_ffine),
        .pulse_on (sh_on),
        .wrap     (sh_wrap),
        .tgt_w    (sh_tgt)
    );

    // period length in coarse steps, rounded up
    logic [TW:0]   steps_x;
    logic [TW:0]   last_x;
    logic [SW-1:0] last_calc;

    assign steps_x   = ({1'b0, period} + (TW+1)'(SUBSTP - 1)) >> FW;
    assign last_x    = steps_x - 1'b1;
    assign last_calc = last_x[SW-1:0];

    // latched per-period parameters
    logic [SW-1:0] lat_rstep, lat_fstep, lat_last;
    logic [FW-1:0] lat_rfine, lat_ffine;
    logic          lat_on, lat_wrap;
    logic [SW-1:0] step;

    pwm_step_timer #(.SW(SW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state != ST_OFF),
        .load      (load),
        .last_step (lat_last),
        .step      (step),
        .at_last   (at_last)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        done_set = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (en) begin
                    state_nx = start_ramp ? ST_RAMP : ST_RUN;
                end
            end
            ST_RAMP: begin
                if (!en) begin
                    state_nx = ST_OFF;
                end else if (at_last && ({1'b0, ss_w_next} >= {1'b0, sh_tgt})) begin
                    state_nx = ST_RUN;
                    done_set = 1'b1;
                end
            end
            ST_RUN: begin
                if (!en) begin
                    state_nx = ST_OFF;
                end
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // state register and per-period storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_OFF;
            lat_rstep <= '0;
            lat_fstep <= '0;
            lat_rfine <= '0;
            lat_ffine <= '0;
            lat_on    <= 1'b0;
            lat_wrap  <= 1'b0;
            lat_last  <= '0;
            ss_w      <= '0;
            ss_seen   <= 1'b0;
            ss_done_q <= 1'b0;
            cfg_err_q <= 1'b0;
        end else begin
            state     <= state_nx;
            cfg_err_q <= ss_en && (edge_base[0] >= TW'(BAN_LO)) && (edge_base[0] <= TW'(BAN_HI));
            if (load) begin
                lat_rstep <= sh_rstep;
                lat_fstep <= sh_fstep;
                lat_rfine <= sh_rfine;
                lat_ffine <= sh_ffine;
                lat_on    <= sh_on;
                lat_wrap  <= sh_wrap;
                lat_last  <= last_calc;
            end
            if (load && ramp_now) begin
                ss_w <= ss_w_next;
            end
            if (start_ramp) begin
                ss_seen   <= 1'b1;
                ss_done_q <= 1'b0;
            end else if (done_set) begin
                ss_done_q <= 1'b1;
            end
        end
    end

    // outputs
    logic running;
    logic in_win;

    always_comb begin
        running      = (state != ST_OFF);
        in_win       = lat_wrap ? ((step >= lat_rstep) || (step < lat_fstep))
                                : ((step >= lat_rstep) && (step < lat_fstep));
        drive        = running && lat_on && in_win;
        period_start = running && (step == '0);
        rise_fine    = (running && lat_on) ? lat_rfine : '0;
        fall_fine    = (running && lat_on) ? lat_ffine : '0;
        ss_active    = (state == ST_RAMP);
        ss_done      = ss_done_q;
        cfg_err      = cfg_err_q;
    end
endmodule

// File: rtl/pwm_edge_gen_chk.sv
module pwm_edge_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic ss_en,
    input logic drive,
    input logic period_start,
    input logic ss_active,
    input logic ss_done,
    input logic cfg_err
);
    assert_off_when_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!drive && !period_start && !ss_active));

    assert_start_needs_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> $past(en));

    assert_start_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> !period_start);

    assert_done_active_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ss_active, ss_done}));

    assert_ramp_ends_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ss_active) && $past(en)) |-> ss_done);

    assert_ramp_starts_at_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_active) |-> period_start);

    assert_cfg_err_needs_ss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(ss_en));
endmodule

bind pwm_edge_gen pwm_edge_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .ss_en        (ss_en),
    .drive        (drive),
    .period_start (period_start),
    .ss_active    (ss_active),
    .ss_done      (ss_done),
    .cfg_err      (cfg_err)
);

// File: tb/tb_pwm_edge_gen.sv
`timescale 1ns/1ps
module tb_pwm_edge_gen;
    localparam int INC = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic en;
    logic [11:0] period;
    logic [7:0]  rise_hi, fall_hi;
    logic [3:0]  rise_lo, fall_lo;
    logic rise_mod_en, rise_mod_neg, fall_mod_en, fall_mod_neg;
    logic cross_ss_only, ss_en, ss_repeat;
    logic signed [9:0] mod_val;
    logic drive, period_start, ss_active, ss_done, cfg_err;
    logic [2:0] rise_fine, fall_fine;

    always #2 clk = ~clk;

    pwm_edge_gen #(.SS_INC(INC)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .period(period),
        .rise_hi(rise_hi), .rise_lo(rise_lo), .fall_hi(fall_hi), .fall_lo(fall_lo),
        .rise_mod_en(rise_mod_en), .rise_mod_neg(rise_mod_neg),
        .fall_mod_en(fall_mod_en), .fall_mod_neg(fall_mod_neg),
        .cross_ss_only(cross_ss_only), .ss_en(ss_en), .ss_repeat(ss_repeat),
        .mod_val(mod_val), .drive(drive), .rise_fine(rise_fine), .fall_fine(fall_fine),
        .period_start(period_start), .ss_active(ss_active), .ss_done(ss_done),
        .cfg_err(cfg_err)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // configuration and model state
    int c_per, c_rise, c_fall, c_mod;
    bit c_rme, c_rmn, c_fme, c_fmn, c_cso, c_sse, c_rep;
    bit b_seen = 0;
    bit b_done = 0;
    int b_w = 0;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic apply();
        period       = c_per[11:0];
        rise_hi      = c_rise[11:4];
        rise_lo      = c_rise[3:0];
        fall_hi      = c_fall[11:4];
        fall_lo      = c_fall[3:0];
        mod_val      = c_mod[9:0];
        rise_mod_en  = c_rme;
        rise_mod_neg = c_rmn;
        fall_mod_en  = c_fme;
        fall_mod_neg = c_fmn;
        cross_ss_only = c_cso;
        ss_en        = c_sse;
        ss_repeat    = c_rep;
    endtask

    task automatic set_cfg(input int per, input int r, input int f, input int m,
                           input bit rme, input bit rmn, input bit fme, input bit fmn,
                           input bit cso, input bit sse, input bit rep);
        c_per = per; c_rise = r; c_fall = f; c_mod = m;
        c_rme = rme; c_rmn = rmn; c_fme = fme; c_fmn = fmn;
        c_cso = cso; c_sse = sse; c_rep = rep;
    endtask

    function automatic int edge_time(input int base, input int m, input bit me,
                                     input bit mn, input int per);
        int v;
        v = base;
        if (me) v = mn ? base - m : base + m;
        if (v < 0) v = 0;
        if (v > per - 1) v = per - 1;
        return v;
    endfunction

    task automatic shape(input int r, input int f, input int per, input int lim,
                         input bit limen, input bit cok,
                         output int rs, output int fs, output bit on, output bit wr,
                         output int tgt, output int rfn, output int ffn);
        int raw, w, fe;
        if (f >= r) raw = f - r;
        else if (cok) raw = per - r + f;
        else raw = 0;
        if (raw > per - 1) raw = per - 1;
        tgt = raw;
        w = (limen && lim < raw) ? lim : raw;
        fe = r + w;
        if (fe >= per) fe = fe - per;
        rs = r / 8; fs = fe / 8;
        rfn = r % 8; ffn = fe % 8;
        on = (rs != fs);
        wr = (fs < rs);
    endtask

    // enable with the current configuration and check nper periods
    task automatic run_periods(input int nper, input string tg);
        int r, f, nsteps, rs, fs, tgt, rfn, ffn, nw;
        bit on, wr, ramp, cok, exp_d, cfg_exp;
        r = edge_time(c_rise, c_mod, c_rme, c_rmn, c_per);
        f = edge_time(c_fall, c_mod, c_fme, c_fmn, c_per);
        nsteps = (c_per + 7) / 8;
        cfg_exp = c_sse && (c_rise >= 16) && (c_rise <= 23);
        ramp = 0;
        @(negedge clk);
        apply();
        en = 1'b1;
        for (int k = 0; k < nper; k++) begin
            if (k == 0) begin
                ramp = c_sse && (c_rep || !b_seen);
                if (ramp) begin b_seen = 1; b_done = 0; b_w = INC; end
                cok = !c_cso || ramp;
                shape(r, f, c_per, b_w, ramp, cok, rs, fs, on, wr, tgt, rfn, ffn);
            end else begin
                cok = !c_cso || ramp;
                if (ramp) begin
                    nw = b_w + INC;
                    if (nw > 4095) nw = 4095;
                    shape(r, f, c_per, nw, 1'b1, cok, rs, fs, on, wr, tgt, rfn, ffn);
                    if (nw >= tgt) begin ramp = 0; b_done = 1; end
                    else b_w = nw;
                end else begin
                    shape(r, f, c_per, 0, 1'b0, cok, rs, fs, on, wr, tgt, rfn, ffn);
                end
            end
            for (int s = 0; s < nsteps; s++) begin
                @(negedge clk);
                exp_d = on && (wr ? (s >= rs || s < fs) : (s >= rs && s < fs));
                check({tg, " drive"}, drive, exp_d);
                check("R1 period_start", period_start, (s == 0));
                if (s == 0) begin
                    check("R8 ss_active", ss_active, ramp);
                    check("R9 ss_done", ss_done, b_done);
                    check("R1 rise_fine", rise_fine, on ? rfn : 0);
                    check("R1 fall_fine", fall_fine, on ? ffn : 0);
                    check("R11 cfg_err", cfg_err, cfg_exp);
                end
            end
        end
        en = 1'b0;
        @(negedge clk);
        check("R12 drive off", drive, 0);
        check("R12 period_start off", period_start, 0);
        check("R12 ss_active off", ss_active, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: act=%0d exp=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        en = 1'b0;
        set_cfg(80, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        apply();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 reset drive", drive, 0);
        check("R12 reset period_start", period_start, 0);
        check("R12 reset ss_active", ss_active, 0);
        check("R9 reset ss_done", ss_done, 0);
        check("R11 reset cfg_err", cfg_err, 0);
        rst_n = 1'b1;

        // R1: rise 20 (step 2, fine 4), fall 50 (step 6, fine 2)
        set_cfg(80, 20, 50, 0, 0, 0, 0, 0, 0, 0, 0);
        run_periods(2, "R1");
        // R2: both edges in step 2
        set_cfg(80, 17, 22, 0, 0, 0, 0, 0, 0, 0, 0);
        run_periods(2, "R2");
        // R3: fall 70 + 50 saturates to 79
        set_cfg(80, 20, 70, 50, 0, 0, 1, 0, 0, 0, 0);
        run_periods(2, "R3");
        // R4: modulation present but rise not enabled
        set_cfg(80, 20, 50, 30, 0, 0, 0, 0, 0, 0, 0);
        run_periods(2, "R4");
        // R5: negative direction moves fall earlier, positive moves rise later
        set_cfg(80, 20, 50, 16, 1, 0, 1, 1, 0, 0, 0);
        run_periods(2, "R5");
        // R6: crossed edges wrap
        set_cfg(80, 60, 20, 0, 0, 0, 0, 0, 0, 0, 0);
        run_periods(2, "R6");
        // R7: crossed edges blocked outside ramp
        set_cfg(80, 60, 20, 0, 0, 0, 0, 0, 1, 0, 0);
        run_periods(2, "R7");
        // R8/R9: first ramp after reset
        set_cfg(80, 0, 64, 0, 0, 0, 0, 0, 0, 1, 0);
        run_periods(10, "R8");
        // R10: no repeat, second enable skips ramp
        run_periods(2, "R10");
        // R10: repeat ramps again
        set_cfg(80, 0, 64, 0, 0, 0, 0, 0, 0, 1, 1);
        run_periods(10, "R10");
        // R7/R8: crossed edges allowed during ramp only
        set_cfg(80, 60, 20, 0, 0, 0, 0, 0, 1, 1, 1);
        run_periods(8, "R7");
        // R11: banned range boundaries
        set_cfg(80, 16, 50, 0, 0, 0, 0, 0, 0, 1, 0);
        run_periods(1, "R11");
        set_cfg(80, 23, 50, 0, 0, 0, 0, 0, 0, 1, 0);
        run_periods(1, "R11");
        set_cfg(80, 24, 50, 0, 0, 0, 0, 0, 0, 1, 0);
        run_periods(1, "R11");
        set_cfg(80, 16, 50, 0, 0, 0, 0, 0, 0, 0, 0);
        run_periods(1, "R11");

        // R13: mid-period change acts at next period
        set_cfg(80, 20, 50, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        apply();
        en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        c_fall = 30;
        apply();
        for (int s = 2; s < 10; s++) begin
            @(negedge clk);
            check("R13 old window", drive, (s >= 2 && s < 6));
        end
        for (int s = 0; s < 10; s++) begin
            @(negedge clk);
            check("R13 new window", drive, (s == 2));
        end
        en = 1'b0;
        @(negedge clk);
        check("R12 off after R13", drive, 0);

        // constrained random configurations
        for (int i = 0; i < 60; i++) begin
            int per;
            per = 64 + int'($urandom % 160);
            set_cfg(per,
                    int'($urandom % (per + 24)),
                    int'($urandom % (per + 24)),
                    int'($urandom % 81) - 40,
                    $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                    $urandom % 2, ($urandom % 3) == 0, $urandom % 2);
            run_periods(c_sse ? 32 : 3, "R1 R3 R5 R6 R8 random");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule